// File: doc/BRIEF.md
# Calendar Time Registers with Deferred Commit

This block keeps the time of day and the calendar date in two packed registers. A one-cycle seconds tick advances them by one second. The increment carries from seconds into minutes, hours, days, months and years. Day rollover follows each month's length, and February's length depends on a stored leap flag. When the year rolls over, the block recomputes the leap flag from the new year.

A bus writes and reads the registers, but a write does not take effect at once. The written word is held in a staging slot, and a per-register busy bit in the control word is raised. On the first seconds tick after the write, the held value replaces the live register and the busy bit drops. While a register's busy bit is set, further writes to it are dropped. Software polls the busy bits before writing again. The whole design runs in one clock domain, with the slow tick acting as an enable.

Top module: `cal_regs`

## Requirements
- R1: After reset the time word reads 0x00000000 (00:00:00), the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag clear) and the control word reads 0.
- R2: The time word holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. All other bits read zero, whatever was written there.
- R3: The date word holds the day in bits 4:0, the month (1 to 12) in bits 11:8, the year offset from 1970 (6 bits, 1970 to 2033) in bits 21:16 and the leap flag in bit 22. All other bits read zero.
- R4: A write to address 2 (time) sets control bit 8 from the next cycle on, and the time word does not change from the write. On the first tick after the write cycle, the written value is loaded and bit 8 clears; both are visible on the cycle after that tick.
- R5: A write to address 1 (date) sets control bit 7 in the same way. The date word is loaded and bit 7 clears on the first tick after the write cycle.
- R6: A write to a register whose busy bit is set is ignored: the value committed is the one from the first write.
- R7: Control bit 9 and every other control bit except 8 and 7 read zero. Writes to address 0 (control) or address 3 have no effect.
- R8: On a tick with no time commit, seconds increment. At 59 seconds the next tick gives 0 and carries into minutes; at 59 minutes the carry gives 0 and carries into hours; at 23 hours the carry gives 0 and advances the date.
- R9: The day advances to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days and February has 28 days, or 29 when the leap flag is set; all other months have 31. After month 12 the month becomes 1 and the year advances.
- R10: On a year advance the offset increments, wrapping from 63 to 0. The leap flag becomes 1 exactly when (1970 + new offset) is divisible by 4.
- R11: A tick that commits a time write does not advance the date. A tick that commits a date write loads the written date, even if the time rolls past midnight on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Write target: 0 control, 1 date, 2 time |
| wr_data | input | 32 | Write data word |
| ctrl_rd | output | 32 | Control word; bit 8 time busy, bit 7 date busy |
| date_rd | output | 32 | Packed date word |
| time_rd | output | 32 | Packed time word |

## Verification
A wrong carry shows up in the time word on the tick that should have carried, so the bench checks every one of the 86,400 ticks of a full day. Errors in month length or leap handling reach the date word only at a month or year boundary. The bench therefore loads the last day of every month, with and without the leap flag, and the last day of every year offset. It then checks the date word one cycle after the tick. A staging slot stuck busy, or one that commits early, shows at the control and data words within one tick of the write. Any write that the block should ignore is followed by a tick so that its effect, if any, would reach the ports.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 6;

    localparam int SEC_LSB  = 0;
    localparam int MIN_LSB  = 8;
    localparam int HOUR_LSB = 16;
    localparam int DAY_LSB  = 0;
    localparam int MON_LSB  = 8;
    localparam int YEAR_LSB = 16;
    localparam int LEAP_BIT = 22;

    localparam int EPOCH_YEAR    = 1970;
    localparam int NUM_SLOTS     = 2;
    localparam int SLOT_DATE     = 0;
    localparam int SLOT_TIME     = 1;
    localparam int CTRL_BUSY_LSB = 7;

    localparam logic [ADDR_W-1:0] ADDR_DATE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_TIME = ADDR_W'(2);

    localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
    localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
    localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);
    localparam logic [MON_W-1:0]  MON_LAST  = MON_W'(12);

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  minute;
        logic [SEC_W-1:0]  second;
    } tod_t;

    typedef struct packed {
        logic              leap;
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  month;
        logic [DAY_W-1:0]  day;
    } ymd_t;

    localparam tod_t TOD_RESET = '{hour: '0, minute: '0, second: '0};
    localparam ymd_t YMD_RESET = '{leap: 1'b0, year: '0, month: MON_W'(1), day: DAY_W'(1)};

    function automatic tod_t word_to_tod(input logic [BUS_W-1:0] w);
        tod_t t;
        t.second = w[SEC_LSB +: SEC_W];
        t.minute = w[MIN_LSB +: MIN_W];
        t.hour   = w[HOUR_LSB +: HOUR_W];
        return t;
    endfunction

    function automatic logic [BUS_W-1:0] tod_to_word(input tod_t t);
        logic [BUS_W-1:0] w;
        w = '0;
        w[SEC_LSB +: SEC_W]   = t.second;
        w[MIN_LSB +: MIN_W]   = t.minute;
        w[HOUR_LSB +: HOUR_W] = t.hour;
        return w;
    endfunction

    function automatic ymd_t word_to_ymd(input logic [BUS_W-1:0] w);
        ymd_t d;
        d.day   = w[DAY_LSB +: DAY_W];
        d.month = w[MON_LSB +: MON_W];
        d.year  = w[YEAR_LSB +: YEAR_W];
        d.leap  = w[LEAP_BIT];
        return d;
    endfunction

    function automatic logic [BUS_W-1:0] ymd_to_word(input ymd_t d);
        logic [BUS_W-1:0] w;
        w = '0;
        w[DAY_LSB +: DAY_W]   = d.day;
        w[MON_LSB +: MON_W]   = d.month;
        w[YEAR_LSB +: YEAR_W] = d.year;
        w[LEAP_BIT]           = d.leap;
        return w;
    endfunction

    function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] m, input logic leap);
        case (m)
            MON_W'(2):                                 return leap ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): return DAY_W'(30);
            default:                                   return DAY_W'(31);
        endcase
    endfunction

    function automatic logic leap_for(input logic [YEAR_W-1:0] y);
        logic [11:0] full;
        full = 12'(EPOCH_YEAR) + 12'(y);
        return full[1:0] == 2'b00;
    endfunction

    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        return (idx == SLOT_TIME) ? ADDR_TIME : ADDR_DATE;
    endfunction

endpackage

// File: rtl/cal_hold_slot.sv
module cal_hold_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    input  logic [W-1:0] data_in,
    input  logic         tick,
    output logic         busy,
    output logic         commit,
    output logic [W-1:0] held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            held <= '0;
        end else if (busy && tick) begin
            busy <= 1'b0;
        end else if (!busy && take) begin
            busy <= 1'b1;
            held <= data_in;
        end
    end

    assign commit = busy & tick;

    // R4
    set_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !busy) |=> busy);

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> busy);

    // R4
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && tick) |=> !busy);

    // R6
    drop_write_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && take) |=> $stable(held));

endmodule

// File: rtl/cal_tod_step.sv
module cal_tod_step
    import cal_pkg::*;
(
    input  tod_t cur,
    output tod_t nxt,
    output logic day_carry
);

    always_comb begin
        nxt       = cur;
        day_carry = 1'b0;
        if (cur.second >= SEC_LAST) begin
            nxt.second = '0;
            if (cur.minute >= MIN_LAST) begin
                nxt.minute = '0;
                if (cur.hour >= HOUR_LAST) begin
                    nxt.hour  = '0;
                    day_carry = 1'b1;
                end else begin
                    nxt.hour = cur.hour + 1'b1;
                end
            end else begin
                nxt.minute = cur.minute + 1'b1;
            end
        end else begin
            nxt.second = cur.second + 1'b1;
        end
    end

endmodule

// File: rtl/cal_date_step.sv
module cal_date_step
    import cal_pkg::*;
(
    input  ymd_t cur,
    output ymd_t nxt
);

    logic              month_end;
    logic [YEAR_W-1:0] year_inc;

    assign month_end = cur.day >= month_days(cur.month, cur.leap);
    assign year_inc  = cur.year + 1'b1;

    always_comb begin
        nxt = cur;
        if (!month_end) begin
            nxt.day = cur.day + 1'b1;
        end else begin
            nxt.day = DAY_W'(1);
            if (cur.month >= MON_LAST) begin
                nxt.month = MON_W'(1);
                nxt.year  = year_inc;
                nxt.leap  = leap_for(year_inc);
            end else begin
                nxt.month = cur.month + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cal_regs.sv
module cal_regs
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  ctrl_rd,
    output logic [BUS_W-1:0]  date_rd,
    output logic [BUS_W-1:0]  time_rd
);

    logic [NUM_SLOTS-1:0] take;
    logic [NUM_SLOTS-1:0] busy;
    logic [NUM_SLOTS-1:0] commit;
    logic [BUS_W-1:0]     slot_word [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign take[g] = wr_en && (wr_addr == slot_addr(g));
        cal_hold_slot #(.W(BUS_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .take    (take[g]),
            .data_in (wr_data),
            .tick    (sec_tick),
            .busy    (busy[g]),
            .commit  (commit[g]),
            .held    (slot_word[g])
        );
    end

    logic unused_word_bits;
    assign unused_word_bits = ^{slot_word[SLOT_DATE], slot_word[SLOT_TIME]};

    tod_t tod_q, tod_next;
    ymd_t ymd_q, ymd_next;
    logic day_carry;

    cal_tod_step u_tod_step (
        .cur       (tod_q),
        .nxt       (tod_next),
        .day_carry (day_carry)
    );

    cal_date_step u_date_step (
        .cur (ymd_q),
        .nxt (ymd_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tod_q <= TOD_RESET;
            ymd_q <= YMD_RESET;
        end else if (sec_tick) begin
            if (commit[SLOT_TIME]) tod_q <= word_to_tod(slot_word[SLOT_TIME]);
            else                   tod_q <= tod_next;
            if (commit[SLOT_DATE])
                ymd_q <= word_to_ymd(slot_word[SLOT_DATE]);
            else if (!commit[SLOT_TIME] && day_carry)
                ymd_q <= ymd_next;
        end
    end

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CTRL_BUSY_LSB +: NUM_SLOTS] = busy;
    end

    assign time_rd = tod_to_word(tod_q);
    assign date_rd = ymd_to_word(ymd_q);

    // R8
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !busy[SLOT_TIME] && tod_q.second < SEC_LAST)
        |=> (tod_q.second == $past(tod_q.second) + 1'b1));

    // R4
    idle_time_chk: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> $stable(tod_q));

    // R11
    date_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (commit[SLOT_TIME] && !commit[SLOT_DATE]) |=> $stable(ymd_q));

    // R5
    idle_date_chk: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> $stable(ymd_q));

endmodule

// File: tb/tb_cal_regs.sv
module tb_cal_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] ctrl_rd, date_rd, time_rd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    cal_regs dut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl_rd(ctrl_rd), .date_rd(date_rd), .time_rd(time_rd)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] tw(input int h, input int m, input int s);
        return 32'((h << 16) | (m << 8) | s);
    endfunction

    function automatic logic [31:0] dw(input int lp, input int y, input int m, input int d);
        return 32'((lp << 22) | (y << 16) | (m << 8) | d);
    endfunction

    function automatic int dim(input int m, input int lp);
        if (m == 2) return lp ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic int lp_of(input int y);
        return ((1970 + y) % 4 == 0) ? 1 : 0;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic tick1();
        sec_tick = 1'b1;
        cyc();
        sec_tick = 1'b0;
    endtask

    task automatic load(input logic [31:0] t, input logic [31:0] d);
        wr(2'd2, t);
        wr(2'd1, d);
        chk(ctrl_rd, 32'h180, "R4 R5 both busy after writes");
        tick1();
        chk(ctrl_rd, 32'h0, "R4 R5 busy cleared on commit tick");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R1 reset state
        chk(time_rd, 32'h0, "R1 time after reset");
        chk(date_rd, 32'h0000_0101, "R1 date after reset");
        chk(ctrl_rd, 32'h0, "R1 ctrl after reset");

        // R4 deferred time write, R2 reserved bits dropped
        wr(2'd2, 32'hFFE0_C0C0 | tw(21, 34, 56));
        chk(ctrl_rd, 32'h100, "R4 time busy bit");
        chk(time_rd, 32'h0, "R4 time not yet applied");
        repeat (4) cyc();
        chk(ctrl_rd, 32'h100, "R4 busy held without tick");
        chk(time_rd, 32'h0, "R4 time held without tick");
        tick1();
        chk(time_rd, tw(21, 34, 56), "R2 time packed fields");
        chk(ctrl_rd, 32'h0, "R4 busy clears at tick");
        chk(date_rd, 32'h0000_0101, "R11 date untouched by time commit");

        // R5 deferred date write, R3 packing
        wr(2'd1, 32'hFF80_E0E0 | dw(1, 42, 2, 17));
        chk(ctrl_rd, 32'h080, "R5 date busy bit");
        chk(date_rd, 32'h0000_0101, "R5 date not yet applied");
        tick1();
        chk(date_rd, dw(1, 42, 2, 17), "R3 date packed fields");
        chk(ctrl_rd, 32'h0, "R5 busy clears at tick");
        chk(time_rd, tw(21, 34, 57), "R8 time ticks while date commits");

        // R6 second write while busy dropped
        wr(2'd2, tw(1, 2, 3));
        wr(2'd2, tw(9, 9, 9));
        wr(2'd1, dw(0, 3, 3, 3));
        wr(2'd1, dw(0, 7, 7, 7));
        tick1();
        chk(time_rd, tw(1, 2, 3), "R6 time keeps first write");
        chk(date_rd, dw(0, 3, 3, 3), "R6 date keeps first write");

        // R7 control and unused address writes ignored
        wr(2'd0, 32'hFFFF_FFFF);
        chk(ctrl_rd, 32'h0, "R7 ctrl write ignored");
        wr(2'd3, 32'hFFFF_FFFF);
        chk(ctrl_rd, 32'h0, "R7 addr 3 write ignored");
        tick1();
        chk(time_rd, tw(1, 2, 4), "R7 time unaffected by stray writes");
        chk(date_rd, dw(0, 3, 3, 3), "R7 date unaffected by stray writes");

        // R11 time commit at midnight blocks date advance
        load(tw(23, 59, 59), dw(0, 3, 3, 10));
        wr(2'd2, tw(4, 5, 6));
        tick1();
        chk(time_rd, tw(4, 5, 6), "R11 time commit");
        chk(date_rd, dw(0, 3, 3, 10), "R11 no date advance on time commit");
        load(tw(23, 59, 59), dw(0, 3, 3, 10));
        wr(2'd1, dw(0, 9, 8, 20));
        tick1();
        chk(time_rd, tw(0, 0, 0), "R8 midnight wrap");
        chk(date_rd, dw(0, 9, 8, 20), "R11 date commit beats carry");

        // R8 full day sweep
        load(tw(0, 0, 0), dw(0, 0, 1, 1));
        for (int n = 1; n <= 86400; n++) begin
            int r;
            tick1();
            r = n % 86400;
            chk(time_rd, tw(r / 3600, (r / 60) % 60, r % 60), "R8 time sweep");
        end
        chk(date_rd, dw(0, 0, 1, 2), "R8 day advance after full day");

        // R9 month ends, with and without leap flag
        for (int m = 1; m <= 12; m++) begin
            for (int lp = 0; lp < 2; lp++) begin
                int last;
                last = dim(m, lp);
                load(tw(23, 59, 59), dw(lp, 5, m, last - 1));
                tick1();
                chk(date_rd, dw(lp, 5, m, last), "R9 day before month end");
                wr(2'd2, tw(23, 59, 59));
                tick1();
                tick1();
                if (m == 12)
                    chk(date_rd, dw(lp_of(6), 6, 1, 1), "R9 december rolls year");
                else
                    chk(date_rd, dw(lp, 5, m + 1, 1), "R9 month end rolls month");
            end
        end

        // R10 every year offset rolls over
        for (int y = 0; y < 64; y++) begin
            int ny;
            ny = (y + 1) % 64;
            load(tw(23, 59, 59), dw(lp_of(y), y, 12, 31));
            tick1();
            chk(date_rd, dw(lp_of(ny), ny, 1, 1), "R10 year rollover and leap");
        end

        done = 1'b1;
        finish_run();
    end

endmodule